// File: doc/BRIEF.md
# Dual-Issue Structural Hazard Checker

This block sits in an in-order issue stage that can send up to two decoded instructions per cycle. Each cycle it looks at the older instruction (slot 0) and the younger one (slot 1). Each arrives as a 4-bit class code and a width bit. For each slot the block says whether it may issue and on which of the two issue pipes. It models the execution resources that can stall issue: the address unit, the branch unit, the integer unit, a multiplier that is not pipelined, the floating unit and a divider that is not pipelined. The occupancy of the multi-cycle resources is held in countdown registers. The block also enforces the cycles near the end of a multiply or divide in which certain other classes are forbidden to issue.

Each slot follows valid/ready rules. `s0_issue` is the ready for slot 0 and `s1_issue` is the ready for slot 1. An instruction is consumed on the rising edge where its valid and issue are both high. Slot 1 is never consumed unless slot 0 is consumed in the same cycle. A slot whose issue is low must hold its instruction until a later cycle. Both issue flags and both pipe selections are combinational functions of the inputs and the countdown state. The countdowns change on the edge where the instruction issues.

Top module: `dual_issue_hazard`

## Requirements
- R1: Class codes and pipe needs.
  - 0 load: either pipe.
  - 1 integer store or store-conditional: pipe 1.
  - 2 floating store: pipe 0.
  - 3 barrier: pipe 1.
  - 4 integer branch, jump or privileged call: pipe 1.
  - 5 floating branch: pipe 0.
  - 6 integer add, logic, shift, conditional move or compare: pipe 0.
  - 7 integer multiply: pipe 0.
  - 8 floating add, multiply, copy-sign or conditional move: pipe 1.
  - 9 floating divide: pipe 1.
  - 11 trap or miscellaneous: pipe 1, no unit.
  - `sN_pipe` reports the chosen pipe, with 0 meaning pipe 0.
- R2: Slot 1 issues only if slot 0 issues, the two use different pipes, and they share no unit. Classes 0 to 3 use the address unit, classes 4 and 5 the branch unit, class 6 the integer unit, class 7 the multiplier, class 8 the floating unit and class 9 the divider. A load takes whichever pipe its partner does not need; with no fixed-pipe partner it takes pipe 0 in slot 0.
- R3: Class 10 (multi-operation) and the unused codes 12 to 15 occupy both pipes. They always issue alone and report pipe 0.
- R4: A barrier holds the address unit for 4 cycles. No class 0 to 3 instruction issues in the 3 cycles after it.
- R5: A branch of class 4 or 5 holds the branch unit for 2 cycles. No branch issues in the cycle after it.
- R6: A multiply with width bit 0 holds the multiplier for 19 cycles, and with width bit 1 for 21 cycles. Its completion cycle follows and uses the integer unit. No multiply issues while the multiplier is held, and no class 6 issues in the completion cycle.
- R7: No class 6 instruction issues exactly 3 cycles before a multiply completes.
- R8: A divide with width bit 0 holds the divider for 30 cycles, and with width bit 1 for 59 cycles. It takes the floating unit in its last divider cycle and in the following completion cycle. No divide issues while the divider is held, and no class 8 issues in those two cycles.
- R9: No class 8 instruction issues exactly 5 or exactly 6 cycles before a divide completes.
- R10: Reset clears every countdown, so any class may issue in the first cycle after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s0_valid | input | 1 | Older instruction present |
| s0_class | input | 4 | Older instruction class code |
| s0_wide | input | 1 | Older instruction width bit (multiply/divide length) |
| s1_valid | input | 1 | Younger instruction present |
| s1_class | input | 4 | Younger instruction class code |
| s1_wide | input | 1 | Younger instruction width bit |
| s0_issue | output | 1 | Older instruction issues this cycle (ready) |
| s0_pipe | output | 1 | Pipe chosen for the older instruction |
| s1_issue | output | 1 | Younger instruction issues this cycle (ready) |
| s1_pipe | output | 1 | Pipe chosen for the younger instruction |

## Verification
The issue and pipe outputs are due in the same cycle as the inputs that cause them. The bench drives each stimulus just after a falling edge and samples 1 ns later, before the rising edge that commits it. Each busy window is counted from the issue edge: the first cycle after an issue is offset 1. The bench steps one cycle per check and computes the blocked offsets from the hold lengths, for example 16 and 19 for a short multiply and 24, 25, 29 and 30 for a short divide. The pairing table runs from a freshly reset state, with a reset between entries, so that no entry depends on another.

// File: rtl/issue_hazard_pkg.sv
package issue_hazard_pkg;

  localparam int CLS_W = 4;

  localparam logic [CLS_W-1:0] CL_LOAD  = 4'd0;
  localparam logic [CLS_W-1:0] CL_IST   = 4'd1;
  localparam logic [CLS_W-1:0] CL_FST   = 4'd2;
  localparam logic [CLS_W-1:0] CL_BAR   = 4'd3;
  localparam logic [CLS_W-1:0] CL_IBR   = 4'd4;
  localparam logic [CLS_W-1:0] CL_FBR   = 4'd5;
  localparam logic [CLS_W-1:0] CL_IALU  = 4'd6;
  localparam logic [CLS_W-1:0] CL_IMUL  = 4'd7;
  localparam logic [CLS_W-1:0] CL_FOP   = 4'd8;
  localparam logic [CLS_W-1:0] CL_FDIV  = 4'd9;
  localparam logic [CLS_W-1:0] CL_MULTI = 4'd10;
  localparam logic [CLS_W-1:0] CL_MISC  = 4'd11;

  localparam int NUM_UNITS = 6;
  localparam int U_ADDR = 0;
  localparam int U_BR   = 1;
  localparam int U_INT  = 2;
  localparam int U_MUL  = 3;
  localparam int U_FP   = 4;
  localparam int U_DIV  = 5;

  typedef enum logic [1:0] {
    PR_P0   = 2'd0,
    PR_P1   = 2'd1,
    PR_ANY  = 2'd2,
    PR_BOTH = 2'd3
  } pipe_req_e;

  typedef struct packed {
    logic                 vld;
    pipe_req_e            req;
    logic [NUM_UNITS-1:0] unit;
    logic                 barrier;
  } op_info_t;

  function automatic op_info_t classify(input logic [CLS_W-1:0] c);
    op_info_t r;
    r = '{vld: 1'b1, req: PR_BOTH, unit: '0, barrier: 1'b0};
    case (c)
      CL_LOAD: begin r.req = PR_ANY; r.unit[U_ADDR] = 1'b1; end
      CL_IST:  begin r.req = PR_P1;  r.unit[U_ADDR] = 1'b1; end
      CL_FST:  begin r.req = PR_P0;  r.unit[U_ADDR] = 1'b1; end
      CL_BAR:  begin r.req = PR_P1;  r.unit[U_ADDR] = 1'b1; r.barrier = 1'b1; end
      CL_IBR:  begin r.req = PR_P1;  r.unit[U_BR]   = 1'b1; end
      CL_FBR:  begin r.req = PR_P0;  r.unit[U_BR]   = 1'b1; end
      CL_IALU: begin r.req = PR_P0;  r.unit[U_INT]  = 1'b1; end
      CL_IMUL: begin r.req = PR_P0;  r.unit[U_MUL]  = 1'b1; end
      CL_FOP:  begin r.req = PR_P1;  r.unit[U_FP]   = 1'b1; end
      CL_FDIV: begin r.req = PR_P1;  r.unit[U_DIV]  = 1'b1; end
      CL_MISC: begin r.req = PR_P1; end
      default: begin r.req = PR_BOTH; end
    endcase
    return r;
  endfunction

endpackage

// File: rtl/issue_slot_decode.sv
module issue_slot_decode
  import issue_hazard_pkg::*;
(
  input  logic             valid,
  input  logic [CLS_W-1:0] cls,
  output op_info_t         info
);
  always_comb begin
    info     = classify(cls);
    info.vld = valid;
  end
endmodule

// File: rtl/issue_busy_timer.sv
module issue_busy_timer #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] count
);
  always_ff @(posedge clk) begin
    if (!rst_n)           count <= '0;
    else if (load)        count <= load_val;
    else if (count != '0) count <= count - 1'b1;
  end
endmodule

// File: rtl/issue_hazard_gate.sv
module issue_hazard_gate
  import issue_hazard_pkg::*;
#(
  parameter int CW        = 6,
  parameter int MUL_GAP   = 3,
  parameter int FP_GAP_A  = 5,
  parameter int FP_GAP_B  = 6
) (
  input  op_info_t        info,
  input  logic [CW-1:0]   addr_cnt,
  input  logic [CW-1:0]   br_cnt,
  input  logic [CW-1:0]   mul_cnt,
  input  logic [CW-1:0]   div_cnt,
  output logic            blocked
);
  localparam logic [CW-1:0] ONE       = CW'(1);
  localparam logic [CW-1:0] TWO       = CW'(2);
  localparam logic [CW-1:0] INT_BAN   = CW'(MUL_GAP + 1);
  localparam logic [CW-1:0] FP_BAN_A  = CW'(FP_GAP_A + 1);
  localparam logic [CW-1:0] FP_BAN_B  = CW'(FP_GAP_B + 1);

  logic int_hit, fp_hit, mul_busy, div_busy;

  always_comb begin
    mul_busy = mul_cnt > ONE;
    div_busy = div_cnt > ONE;
    int_hit  = (mul_cnt == ONE) || (mul_cnt == INT_BAN);
    fp_hit   = (div_cnt == ONE) || (div_cnt == TWO) ||
               (div_cnt == FP_BAN_A) || (div_cnt == FP_BAN_B);
    blocked  = (info.unit[U_ADDR] && (addr_cnt != '0)) ||
               (info.unit[U_BR]   && (br_cnt   != '0)) ||
               (info.unit[U_INT]  && int_hit)          ||
               (info.unit[U_MUL]  && mul_busy)         ||
               (info.unit[U_FP]   && fp_hit)           ||
               (info.unit[U_DIV]  && div_busy);
  end
endmodule

// File: rtl/issue_pair_select.sv
module issue_pair_select
  import issue_hazard_pkg::*;
(
  input  op_info_t info0,
  input  op_info_t info1,
  input  logic     blk0,
  input  logic     blk1,
  output logic     issue0,
  output logic     pipe0,
  output logic     issue1,
  output logic     pipe1
);
  logic partner_p0, clash;

  always_comb begin
    partner_p0 = info1.vld && (info1.req == PR_P0);
    pipe0      = (info0.req == PR_P1) || ((info0.req == PR_ANY) && partner_p0);
    case (info1.req)
      PR_P0:   pipe1 = 1'b0;
      PR_P1:   pipe1 = 1'b1;
      PR_ANY:  pipe1 = ~pipe0;
      default: pipe1 = 1'b0;
    endcase
    clash  = ((info0.unit & info1.unit) != '0) ||
             (info0.req == PR_BOTH) || (info1.req == PR_BOTH) ||
             (pipe0 == pipe1);
    issue0 = info0.vld && !blk0;
    issue1 = issue0 && info1.vld && !blk1 && !clash;
  end
endmodule

// File: rtl/dual_issue_hazard.sv
module dual_issue_hazard
  import issue_hazard_pkg::*;
#(
  parameter int BAR_HOLD  = 4,
  parameter int BR_HOLD   = 2,
  parameter int MUL_SHORT = 19,
  parameter int MUL_LONG  = 21,
  parameter int DIV_SHORT = 30,
  parameter int DIV_LONG  = 59,
  parameter int MUL_GAP   = 3,
  parameter int FP_GAP_A  = 5,
  parameter int FP_GAP_B  = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             s0_valid,
  input  logic [CLS_W-1:0] s0_class,
  input  logic             s0_wide,
  input  logic             s1_valid,
  input  logic [CLS_W-1:0] s1_class,
  input  logic             s1_wide,
  output logic             s0_issue,
  output logic             s0_pipe,
  output logic             s1_issue,
  output logic             s1_pipe
);
  localparam int LONGEST = (DIV_LONG > MUL_LONG) ? DIV_LONG : MUL_LONG;
  localparam int CW      = $clog2(LONGEST + 1);
  localparam int SLOTS   = 2;

  logic [SLOTS-1:0] vld_a;
  logic [CLS_W-1:0] cls_a [SLOTS];
  logic [SLOTS-1:0] wide_a;
  op_info_t         info_a [SLOTS];
  logic [SLOTS-1:0] blk_a;
  logic [SLOTS-1:0] go;

  logic [CW-1:0] addr_cnt, br_cnt, mul_cnt, div_cnt;
  logic          bar_go, br_go, mul_go, div_go, mul_w, div_w;
  logic [CW-1:0] mul_len, div_len;

  assign vld_a  = {s1_valid, s0_valid};
  assign wide_a = {s1_wide, s0_wide};
  assign cls_a[0] = s0_class;
  assign cls_a[1] = s1_class;

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    issue_slot_decode u_dec (
      .valid (vld_a[s]),
      .cls   (cls_a[s]),
      .info  (info_a[s])
    );
    issue_hazard_gate #(
      .CW       (CW),
      .MUL_GAP  (MUL_GAP),
      .FP_GAP_A (FP_GAP_A),
      .FP_GAP_B (FP_GAP_B)
    ) u_gate (
      .info     (info_a[s]),
      .addr_cnt (addr_cnt),
      .br_cnt   (br_cnt),
      .mul_cnt  (mul_cnt),
      .div_cnt  (div_cnt),
      .blocked  (blk_a[s])
    );
  end

  issue_pair_select u_pair (
    .info0  (info_a[0]),
    .info1  (info_a[1]),
    .blk0   (blk_a[0]),
    .blk1   (blk_a[1]),
    .issue0 (s0_issue),
    .pipe0  (s0_pipe),
    .issue1 (s1_issue),
    .pipe1  (s1_pipe)
  );

  assign go = {s1_issue, s0_issue};

  always_comb begin
    bar_go  = (go[0] && info_a[0].barrier)      || (go[1] && info_a[1].barrier);
    br_go   = (go[0] && info_a[0].unit[U_BR])   || (go[1] && info_a[1].unit[U_BR]);
    mul_go  = (go[0] && info_a[0].unit[U_MUL])  || (go[1] && info_a[1].unit[U_MUL]);
    div_go  = (go[0] && info_a[0].unit[U_DIV])  || (go[1] && info_a[1].unit[U_DIV]);
    mul_w   = (go[0] && info_a[0].unit[U_MUL]) ? wide_a[0] : wide_a[1];
    div_w   = (go[0] && info_a[0].unit[U_DIV]) ? wide_a[0] : wide_a[1];
    mul_len = mul_w ? CW'(MUL_LONG) : CW'(MUL_SHORT);
    div_len = div_w ? CW'(DIV_LONG) : CW'(DIV_SHORT);
  end

  issue_busy_timer #(.W(CW)) u_addr_t (
    .clk(clk), .rst_n(rst_n), .load(bar_go), .load_val(CW'(BAR_HOLD - 1)), .count(addr_cnt));
  issue_busy_timer #(.W(CW)) u_br_t (
    .clk(clk), .rst_n(rst_n), .load(br_go), .load_val(CW'(BR_HOLD - 1)), .count(br_cnt));
  issue_busy_timer #(.W(CW)) u_mul_t (
    .clk(clk), .rst_n(rst_n), .load(mul_go), .load_val(mul_len), .count(mul_cnt));
  issue_busy_timer #(.W(CW)) u_div_t (
    .clk(clk), .rst_n(rst_n), .load(div_go), .load_val(div_len), .count(div_cnt));

endmodule

// File: rtl/issue_hazard_chk.sv
module issue_hazard_chk
  import issue_hazard_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             s0_valid,
  input logic [CLS_W-1:0] s0_class,
  input logic             s0_wide,
  input logic             s1_valid,
  input logic [CLS_W-1:0] s1_class,
  input logic             s1_wide,
  input logic             s0_issue,
  input logic             s0_pipe,
  input logic             s1_issue,
  input logic             s1_pipe
);
  op_info_t k0, k1;
  logic mem0, mem1, brn0, brn1, mul0, mul1, div0, div1;

  always_comb begin
    k0   = classify(s0_class);
    k1   = classify(s1_class);
    mem0 = s0_issue && k0.unit[U_ADDR];
    mem1 = s1_issue && k1.unit[U_ADDR];
    brn0 = s0_issue && k0.unit[U_BR];
    brn1 = s1_issue && k1.unit[U_BR];
    mul0 = s0_issue && k0.unit[U_MUL];
    mul1 = s1_issue && k1.unit[U_MUL];
    div0 = s0_issue && k0.unit[U_DIV];
    div1 = s1_issue && k1.unit[U_DIV];
  end

  p_young_after_old_r2: assert property (@(posedge clk) disable iff (!rst_n)
    s1_issue |-> s0_issue && s0_valid && s1_valid);

  p_pipes_distinct_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (s0_issue && s1_issue) |-> (s0_pipe != s1_pipe));

  p_int_pipe0_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (s0_issue && s0_class == CL_IALU) |-> !s0_pipe);

  p_multi_alone_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (s0_issue && s0_class == CL_MULTI) |-> !s1_issue);

  p_barrier_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((s0_issue && s0_class == CL_BAR) || (s1_issue && s1_class == CL_BAR))
      |=> !mem0 && !mem1);

  p_branch_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (brn0 || brn1) |=> !brn0 && !brn1);

  p_mul_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mul0 || mul1) |=> !mul0 && !mul1);

  p_div_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (div0 || div1) |=> !div0 && !div1);

endmodule

bind dual_issue_hazard issue_hazard_chk u_chk (.*);

// File: tb/tb_dual_issue_hazard.sv
`timescale 1ns/1ps
module tb_dual_issue_hazard;

  localparam time CLK_P = 4ns;
  localparam int  M_S = 19, M_L = 21, D_S = 30, D_L = 59;

  logic clk = 1'b0, rst_n = 1'b0;
  logic s0_valid = 0, s0_wide = 0, s1_valid = 0, s1_wide = 0;
  logic [3:0] s0_class = '0, s1_class = '0;
  logic s0_issue, s0_pipe, s1_issue, s1_pipe;

  int checks = 0, failures = 0;

  always #(CLK_P/2) clk = ~clk;

  dual_issue_hazard dut (.*);

  // vector: {req[3:0], v0, c0[3:0], w0, v1, c1[3:0], w1, i0, i1, p0, p1}
  localparam int NV = 19;
  localparam logic [19:0] VEC [NV] = '{
    {4'd1, 1'b1,4'd0,1'b0, 1'b0,4'd0,1'b0, 4'b1000},  // R1 lone load on pipe 0
    {4'd2, 1'b1,4'd6,1'b0, 1'b1,4'd8,1'b0, 4'b1101},  // R2 int + fp pair
    {4'd2, 1'b1,4'd8,1'b0, 1'b1,4'd6,1'b0, 4'b1110},  // R2 fp + int pair
    {4'd2, 1'b1,4'd6,1'b0, 1'b1,4'd6,1'b0, 4'b1000},  // R2 two int ops
    {4'd2, 1'b1,4'd0,1'b0, 1'b1,4'd6,1'b0, 4'b1110},  // R2 load yields pipe 0
    {4'd2, 1'b1,4'd6,1'b0, 1'b1,4'd0,1'b0, 4'b1101},  // R2 younger load to pipe 1
    {4'd2, 1'b1,4'd0,1'b0, 1'b1,4'd0,1'b0, 4'b1000},  // R2 two loads share address unit
    {4'd3, 1'b1,4'd10,1'b0, 1'b1,4'd11,1'b0, 4'b1000}, // R3 multi first
    {4'd3, 1'b1,4'd11,1'b0, 1'b1,4'd10,1'b0, 4'b1010}, // R3 multi second
    {4'd2, 1'b1,4'd1,1'b0, 1'b1,4'd2,1'b0, 4'b1010},  // R2 two stores
    {4'd2, 1'b1,4'd4,1'b0, 1'b1,4'd5,1'b0, 4'b1010},  // R2 two branches
    {4'd1, 1'b1,4'd2,1'b0, 1'b1,4'd11,1'b0, 4'b1101}, // R1 fp store + misc
    {4'd2, 1'b0,4'd0,1'b0, 1'b1,4'd6,1'b0, 4'b0000},  // R2 younger alone waits
    {4'd1, 1'b1,4'd7,1'b1, 1'b1,4'd9,1'b1, 4'b1101},  // R1 multiply + divide
    {4'd2, 1'b1,4'd8,1'b0, 1'b1,4'd9,1'b0, 4'b1010},  // R2 both want pipe 1
    {4'd1, 1'b1,4'd5,1'b0, 1'b1,4'd1,1'b0, 4'b1101},  // R1 fp branch + int store
    {4'd2, 1'b1,4'd0,1'b0, 1'b1,4'd2,1'b0, 4'b1010},  // R2 load moves to pipe 1
    {4'd4, 1'b1,4'd3,1'b0, 1'b1,4'd0,1'b0, 4'b1010},  // R4 barrier + load same cycle
    {4'd3, 1'b1,4'd13,1'b0, 1'b1,4'd11,1'b0, 4'b1000} // R3 unused code alone
  };

  task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp, input logic [3:0] mask);
    checks++;
    if ((act & mask) !== (exp & mask)) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", tag, act & mask, exp & mask);
    end
  endtask

  task automatic step(input logic v0, input logic [3:0] c0, input logic w0,
                      input logic v1, input logic [3:0] c1, input logic w1);
    @(negedge clk);
    s0_valid = v0; s0_class = c0; s0_wide = w0;
    s1_valid = v1; s1_class = c1; s1_wide = w1;
    #1ns;
  endtask

  task automatic one(input logic [3:0] c, input logic w);
    step(1'b1, c, w, 1'b0, 4'd0, 1'b0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; s0_valid = 0; s1_valid = 0;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  function automatic logic [3:0] outs();
    return {s0_issue, s1_issue, s0_pipe, s1_pipe};
  endfunction

  initial begin
    #(CLK_P * 100000);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    do_reset();

    // Pairing table, each entry from a reset state (R1 R2 R3)
    for (int i = 0; i < NV; i++) begin
      logic [19:0] v;
      logic [3:0]  e, m;
      v = VEC[i];
      step(v[15], v[14:11], v[10], v[9], v[8:5], v[4]);
      e = v[3:0];
      m = {2'b11, e[3], e[2]};
      chk($sformatf("R%0d vector %0d", v[19:16], i), outs(), e, m);
      do_reset();
    end

    // R4: barrier blocks address-unit classes for 3 cycles
    one(4'd3, 1'b0);
    chk("R4 barrier issues", outs(), 4'b1000, 4'b1100);
    step(1'b1, 4'd6, 1'b0, 1'b1, 4'd0, 1'b0);
    chk("R4 load in slot 1 at +1", outs(), 4'b1000, 4'b1100);
    for (int k = 2; k <= 4; k++) begin
      one(4'd0, 1'b0);
      chk($sformatf("R4 load at +%0d", k), outs(), {k == 4, 3'b000}, 4'b1000);
    end

    // R5: branch unit two cycles
    do_reset();
    one(4'd4, 1'b0);
    chk("R5 int branch issues", outs(), 4'b1000, 4'b1000);
    one(4'd5, 1'b0);
    chk("R5 fp branch at +1", outs(), 4'b0000, 4'b1000);
    one(4'd5, 1'b0);
    chk("R5 fp branch at +2", outs(), 4'b1000, 4'b1000);

    // R2: a barrier issued from slot 1 holds the address unit
    do_reset();
    step(1'b1, 4'd6, 1'b0, 1'b1, 4'd3, 1'b0);
    chk("R2 barrier in slot 1 issues", outs(), 4'b1100, 4'b1100);
    one(4'd2, 1'b0);
    chk("R2 fp store after slot-1 barrier", outs(), 4'b0000, 4'b1000);

    // R6 R7: short multiply
    do_reset();
    one(4'd7, 1'b0);
    chk("R6 short multiply issues", outs(), 4'b1000, 4'b1000);
    for (int k = 1; k <= M_S + 1; k++) begin
      if (k == M_S - 1) begin
        one(4'd7, 1'b0);
        chk($sformatf("R6 multiply at +%0d", k), outs(), 4'b0000, 4'b1000);
      end else begin
        one(4'd6, 1'b0);
        chk($sformatf("R7 int op at +%0d (short)", k), outs(),
            {!(k == M_S - 3 || k == M_S), 3'b000}, 4'b1000);
      end
    end

    // R6 R7: long multiply
    do_reset();
    one(4'd7, 1'b1);
    chk("R6 long multiply issues", outs(), 4'b1000, 4'b1000);
    for (int k = 1; k <= M_L; k++) begin
      if (k == M_L - 1 || k == M_L) begin
        one(4'd7, 1'b0);
        chk($sformatf("R6 multiply at +%0d (long)", k), outs(), {k == M_L, 3'b000}, 4'b1000);
      end else begin
        one(4'd6, 1'b0);
        chk($sformatf("R7 int op at +%0d (long)", k), outs(),
            {!(k == M_L - 3), 3'b000}, 4'b1000);
      end
    end

    // R8 R9: short divide
    do_reset();
    one(4'd9, 1'b0);
    chk("R8 short divide issues", outs(), 4'b1000, 4'b1000);
    for (int k = 1; k <= D_S + 1; k++) begin
      if (k == D_S - 1) begin
        one(4'd9, 1'b0);
        chk($sformatf("R8 divide at +%0d", k), outs(), 4'b0000, 4'b1000);
      end else begin
        one(4'd8, 1'b0);
        chk($sformatf("R9 fp op at +%0d (short)", k), outs(),
            {!(k == D_S - 5 || k == D_S - 6 || k == D_S), 3'b000}, 4'b1000);
      end
    end

    // R8 R9: long divide
    do_reset();
    one(4'd9, 1'b1);
    chk("R8 long divide issues", outs(), 4'b1000, 4'b1000);
    for (int k = 1; k <= D_L; k++) begin
      if (k == D_L) begin
        one(4'd9, 1'b0);
        chk("R8 divide at completion (long)", outs(), 4'b1000, 4'b1000);
      end else begin
        one(4'd8, 1'b0);
        chk($sformatf("R9 fp op at +%0d (long)", k), outs(),
            {!(k == D_L - 5 || k == D_L - 6 || k == D_L - 1), 3'b000}, 4'b1000);
      end
    end

    // R10: reset clears every countdown
    do_reset();
    step(1'b1, 4'd7, 1'b1, 1'b1, 4'd9, 1'b1);
    chk("R10 load busy units", outs(), 4'b1100, 4'b1100);
    step(1'b1, 4'd4, 1'b0, 1'b0, 4'd0, 1'b0);
    do_reset();
    step(1'b1, 4'd7, 1'b0, 1'b1, 4'd9, 1'b0);
    chk("R10 multiply and divide after reset", outs(), 4'b1100, 4'b1100);
    do_reset();
    step(1'b1, 4'd5, 1'b0, 1'b1, 4'd8, 1'b0);
    chk("R10 branch and fp op after reset", outs(), 4'b1100, 4'b1100);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule